// File: doc/BRIEF.md
# Multi-Drop Serial Receiver with Address Filter

This block receives asynchronous serial characters from a line that several nodes share. Each character starts with a low start bit. The data bits follow, least significant first, then an optional even parity bit and a stop bit. The receiver runs off an oversampling tick taken from an integer baud divisor. It confirms the start bit at mid-bit and decides every bit by a three-sample majority vote around the bit centre. Each finished character goes into a two-entry receive queue as a word that carries the data and three flags: address/data, framing error and parity error.

On a shared bus, a node usually cares only about address characters until software recognises its own address. With the filter enabled, the receiver drops every character whose address marker is 0 before it reaches the queue. For 5 to 8 data bits the marker is the first stop bit. For 9 data bits it is bit 8 of the data.

Top module: `mdrop_uart_rx`

## Requirements
- R1: After reset the queue is empty, `rd_valid` is 0 and `ovr_pulse` is 0.
- R2: A character is a low start bit, then N data bits LSB first, then a parity bit if `par_en` is 1, then a stop bit. N is 5, 6, 7 or 8 for `char_sel` 0, 1, 2 or 3, and N is 9 for `char_sel` 4 or higher. `rd_data` holds the data zero-extended to 9 bits.
- R3: One oversampling tick occurs every `baud_div`+1 clocks. One bit lasts 16 ticks when `dbl_speed` is 0 and 8 ticks when `dbl_speed` is 1. Each bit value is the majority of three samples at the middle of the bit.
- R4: A low level that is gone before the middle of the start bit does not start a character, and nothing is queued.
- R5: For N of 5 to 8, `rd_addr` equals the sampled first stop bit. For N = 9, `rd_addr` equals data bit 8. A value of 1 means an address character.
- R6: When `filter_en` is 1, a character with an address marker of 0 is discarded and never queued.
- R7: A stop bit sampled low sets `rd_ferr` in that entry. The receiver then waits for the line to return high before it looks for a new start bit.
- R8: With `par_en` set, the parity is even. `rd_perr` is 1 when the XOR of the data bits and the parity bit is 1.
- R9: The queue holds two entries and is first-in first-out. `rd_pop` removes the head entry.
- R10: A character that would be queued while the queue is full raises `ovr_pulse` for one clock and is not stored. The entries already queued stay unchanged.
- R11: In normal speed, 5-bit characters without parity are received correctly when the sender's bit period differs from the nominal one by +3% or -3%.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Serial line, idle high |
| baud_div | input | DIV_W | Oversampling tick period minus one, in clocks |
| dbl_speed | input | 1 | 1 = 8 ticks per bit, 0 = 16 ticks per bit |
| char_sel | input | 3 | Character size select (0..3 = 5..8 bits, 4+ = 9 bits) |
| par_en | input | 1 | Expect an even parity bit |
| filter_en | input | 1 | Discard characters with address marker 0 |
| rd_pop | input | 1 | Remove the head entry of the queue |
| rd_valid | output | 1 | Queue holds at least one entry |
| rd_data | output | 9 | Head entry data, zero-extended |
| rd_addr | output | 1 | Head entry address marker |
| rd_ferr | output | 1 | Head entry framing error |
| rd_perr | output | 1 | Head entry parity error |
| ovr_pulse | output | 1 | One-clock pulse when a character is lost to a full queue |

## Verification
The bench builds the block with its default parameters: an 8-bit divisor, a two-entry queue and two synchroniser stages. It drives a divisor of 3 in normal speed and 7 in double speed. Both give a 64-clock nominal bit, so the two oversampling rates can be compared on identical stimulus. A bit period of 64 clocks lets the bench move the sender's period by whole clocks to ±3%, and lets a 20-clock glitch end well before the mid-bit check. With two queue entries, three unread characters are enough to reach the overrun case.

// File: rtl/mdrop_rx_pkg.sv
package mdrop_rx_pkg;

  localparam int MAX_BITS = 9;

  typedef struct packed {
    logic [MAX_BITS-1:0] data;
    logic                addr;
    logic                ferr;
    logic                perr;
  } rx_entry_t;

  localparam int ENTRY_W = $bits(rx_entry_t);

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP,
    S_HOLD
  } rx_state_t;

  function automatic logic [3:0] char_bits(input logic [2:0] sel);
    if (sel >= 3'd4) return 4'd9;
    return 4'd5 + {1'b0, sel};
  endfunction

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/mdrop_rx_sync.sv
module mdrop_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] shr;

  always_ff @(posedge clk) begin
    if (rst) shr <= '1;
    else     shr <= {shr[STAGES-2:0], din};
  end

  assign dout = shr[STAGES-1];
endmodule

// File: rtl/mdrop_rx_tick.sv
module mdrop_rx_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= div) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
    (tick && div != '0) |=> !tick); // R3
endmodule

// File: rtl/mdrop_rx_frame.sv
module mdrop_rx_frame
  import mdrop_rx_pkg::*;
#(
  parameter int OS_NORM = 16,
  parameter int OS_DBL  = 8
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      tick,
  input  logic      rx,
  input  logic      dbl,
  input  logic [2:0] char_sel,
  input  logic      par_en,
  output logic      done,
  output rx_entry_t ent
);
  localparam int PW  = $clog2(OS_NORM);
  localparam int BIW = $clog2(MAX_BITS + 1);

  rx_state_t          st;
  logic [PW-1:0]      ph;
  logic [PW-1:0]      ph_last, ph_s0, ph_s1, ph_vote;
  logic               s0, s1, bitv, par_bit, pen_l;
  logic [BIW-1:0]     bit_idx;
  logic [3:0]         nb;
  logic [MAX_BITS-1:0] shreg;

  assign ph_last = dbl ? PW'(OS_DBL - 1)   : PW'(OS_NORM - 1);
  assign ph_s0   = dbl ? PW'(OS_DBL/2 - 1) : PW'(OS_NORM/2 - 1);
  assign ph_s1   = dbl ? PW'(OS_DBL/2)     : PW'(OS_NORM/2);
  assign ph_vote = dbl ? PW'(OS_DBL/2 + 1) : PW'(OS_NORM/2 + 1);
  assign bitv    = maj3(s0, s1, rx);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      ph      <= '0;
      s0      <= 1'b1;
      s1      <= 1'b1;
      bit_idx <= '0;
      nb      <= 4'd8;
      pen_l   <= 1'b0;
      shreg   <= '0;
      par_bit <= 1'b0;
      done    <= 1'b0;
      ent     <= '0;
    end else begin
      done <= 1'b0;
      if (st == S_HOLD) begin
        if (rx) st <= S_IDLE;
      end else if (tick) begin
        if (ph == ph_s0) s0 <= rx;
        if (ph == ph_s1) s1 <= rx;
        ph <= (ph == ph_last) ? '0 : ph + 1'b1;
        case (st)
          S_IDLE: begin
            ph <= '0;
            if (!rx) begin
              st    <= S_START;
              ph    <= PW'(1);
              nb    <= char_bits(char_sel);
              pen_l <= par_en;
              shreg <= '0;
            end
          end
          S_START: begin
            if (ph == ph_vote && bitv) begin
              st <= S_IDLE;
              ph <= '0;
            end else if (ph == ph_last) begin
              st      <= S_DATA;
              bit_idx <= '0;
            end
          end
          S_DATA: begin
            if (ph == ph_vote) shreg[bit_idx] <= bitv;
            if (ph == ph_last) begin
              if (bit_idx == BIW'(nb - 4'd1)) st <= pen_l ? S_PAR : S_STOP;
              else bit_idx <= bit_idx + 1'b1;
            end
          end
          S_PAR: begin
            if (ph == ph_vote) par_bit <= bitv;
            if (ph == ph_last) st <= S_STOP;
          end
          S_STOP: begin
            if (ph == ph_vote) begin
              done      <= 1'b1;
              ent.data  <= shreg;
              ent.addr  <= (nb == 4'd9) ? shreg[MAX_BITS-1] : bitv;
              ent.ferr  <= !bitv;
              ent.perr  <= pen_l && ((^shreg) ^ par_bit);
              st        <= bitv ? S_IDLE : S_HOLD;
              ph        <= '0;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
    (st == S_START && $past(st) == S_IDLE) |-> !$past(rx)); // R4
  AST_HOLD_UNTIL_HIGH: assert property (@(posedge clk) disable iff (rst)
    (st == S_HOLD && !rx) |=> st == S_HOLD); // R7
  AST_DONE_FROM_STOP: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(st) == S_STOP); // R2
endmodule

// File: rtl/mdrop_rx_fifo.sv
module mdrop_rx_fifo #(
  parameter int DEPTH = 2,
  parameter int W     = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          do_wr, do_rd;

  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && !empty;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_wr) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (do_rd) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      cnt <= cnt + CW'(do_wr) - CW'(do_rd);
    end
  end

  assign rd_data = mem[rptr];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH)); // R9
  AST_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (rd_en && empty && !wr_en) |=> empty); // R9
  AST_FULL_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full && !rd_en) |=> full && $stable(rptr)); // R10
endmodule

// File: rtl/mdrop_uart_rx.sv
module mdrop_uart_rx
  import mdrop_rx_pkg::*;
#(
  parameter int DIV_W     = 8,
  parameter int FIFO_DEPTH = 2,
  parameter int SYNC_STG  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rxd,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             dbl_speed,
  input  logic [2:0]       char_sel,
  input  logic             par_en,
  input  logic             filter_en,
  input  logic             rd_pop,
  output logic             rd_valid,
  output logic [8:0]       rd_data,
  output logic             rd_addr,
  output logic             rd_ferr,
  output logic             rd_perr,
  output logic             ovr_pulse
);
  logic      rx_s, tick, done, push, q_empty, q_full;
  rx_entry_t ent, head;

  mdrop_rx_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst(rst), .din(rxd), .dout(rx_s));

  mdrop_rx_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .div(baud_div), .tick(tick));

  mdrop_rx_frame u_frame (
    .clk(clk), .rst(rst), .tick(tick), .rx(rx_s), .dbl(dbl_speed),
    .char_sel(char_sel), .par_en(par_en), .done(done), .ent(ent));

  assign push = done && (!filter_en || ent.addr);

  mdrop_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(ENTRY_W)) u_fifo (
    .clk(clk), .rst(rst), .wr_en(push), .wr_data(ent), .rd_en(rd_pop),
    .rd_data(head), .empty(q_empty), .full(q_full));

  always_ff @(posedge clk) begin
    if (rst) ovr_pulse <= 1'b0;
    else     ovr_pulse <= push && q_full;
  end

  assign rd_valid = !q_empty;
  assign rd_data  = head.data;
  assign rd_addr  = head.addr;
  assign rd_ferr  = head.ferr;
  assign rd_perr  = head.perr;

  AST_OVR_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
    ovr_pulse |-> $past(q_full)); // R10
  AST_OVR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ovr_pulse |-> $past(done)); // R10
endmodule

// File: tb/tb_mdrop_uart_rx.sv
module tb_mdrop_uart_rx;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rxd = 1'b1;
  logic [7:0] baud_div = 8'd3;
  logic       dbl_speed = 1'b0;
  logic [2:0] char_sel = 3'd3;
  logic       par_en = 1'b0;
  logic       filter_en = 1'b0;
  logic       rd_pop = 1'b0;
  logic       rd_valid, rd_addr, rd_ferr, rd_perr, ovr_pulse;
  logic [8:0] rd_data;

  int tot = 0, bad = 0, ovr_seen = 0, exp_ovr = 0, cyc = 0;
  logic [11:0] q[$];

  always #10 clk = ~clk;

  mdrop_uart_rx dut (
    .clk(clk), .rst(rst), .rxd(rxd), .baud_div(baud_div), .dbl_speed(dbl_speed),
    .char_sel(char_sel), .par_en(par_en), .filter_en(filter_en), .rd_pop(rd_pop),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_addr(rd_addr), .rd_ferr(rd_ferr),
    .rd_perr(rd_perr), .ovr_pulse(ovr_pulse));

  always @(negedge clk) begin
    cyc++;
    if (!rst && ovr_pulse) ovr_seen++;
    if (cyc > 150000) begin
      tot++; bad++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
      $display("%0d/%0d checks passed", tot - bad, tot);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tot++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input int n);
    rxd = v;
    repeat (n) @(negedge clk);
  endtask

  // one character plus a second high stop bit, then the model update
  task automatic frame(input int nb, input logic [8:0] d, input logic pen,
                       input logic flip_par, input logic stp, input int bp);
    logic [8:0] m;
    logic pb, a;
    m = d & 9'((1 << nb) - 1);
    pb = (^m) ^ flip_par;
    drive(1'b0, bp);
    for (int i = 0; i < nb; i++) drive(m[i], bp);
    if (pen) drive(pb, bp);
    drive(stp, bp);
    drive(1'b1, bp);
    drive(1'b1, 8);
    a = (nb == 9) ? m[8] : stp;
    if (!filter_en || a) begin
      if (q.size() >= 2) exp_ovr++;
      else q.push_back({m, a, !stp, pen & flip_par});
    end
  endtask

  task automatic drain(input string req);
    while (q.size() > 0) begin
      logic [11:0] e;
      e = q.pop_front();
      chk(rd_valid == 1'b1, {req, " valid"}, rd_valid, 1);
      chk({rd_data, rd_addr, rd_ferr, rd_perr} == e, {req, " entry"},
          {rd_data, rd_addr, rd_ferr, rd_perr}, e);
      rd_pop = 1'b1;
      @(negedge clk);
      rd_pop = 1'b0;
    end
    chk(rd_valid == 1'b0, {req, " empty"}, rd_valid, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rd_valid == 1'b0, "R1 valid after reset", rd_valid, 0);
    chk(ovr_pulse == 1'b0, "R1 overrun after reset", ovr_pulse, 0);
    drive(1'b1, 40);

    // R2 R5: 8-bit address character
    char_sel = 3'd3;
    frame(8, 9'h0A5, 0, 0, 1, 64);
    drain("R2 R5 8-bit");
    // R2: 5-bit zero-extended
    char_sel = 3'd0;
    frame(5, 9'h013, 0, 0, 1, 64);
    drain("R2 5-bit");
    // R8: 7-bit even parity good and bad
    char_sel = 3'd2; par_en = 1'b1;
    frame(7, 9'h05A, 1, 0, 1, 64);
    frame(7, 9'h033, 1, 1, 1, 64);
    drain("R8 parity");
    par_en = 1'b0;
    // R5: 9-bit marker from bit 8
    char_sel = 3'd4;
    frame(9, 9'h1C3, 0, 0, 1, 64);
    frame(9, 9'h042, 0, 0, 1, 64);
    drain("R5 9-bit");
    // R7: framing error then recovery
    char_sel = 3'd3;
    frame(8, 9'h03C, 0, 0, 0, 64);
    frame(8, 9'h0C3, 0, 0, 1, 64);
    drain("R7 framing");
    // R6: filter in 8-bit mode
    filter_en = 1'b1;
    frame(8, 9'h011, 0, 0, 0, 64);
    chk(rd_valid == 1'b0, "R6 data dropped 8-bit", rd_valid, 0);
    frame(8, 9'h022, 0, 0, 1, 64);
    drain("R6 address kept 8-bit");
    // R6: filter in 9-bit mode
    char_sel = 3'd4;
    frame(9, 9'h0F0, 0, 0, 1, 64);
    chk(rd_valid == 1'b0, "R6 data dropped 9-bit", rd_valid, 0);
    frame(9, 9'h10F, 0, 0, 1, 64);
    drain("R6 address kept 9-bit");
    filter_en = 1'b0;
    // R4: glitch shorter than half a bit
    char_sel = 3'd3;
    drive(1'b0, 20);
    drive(1'b1, 200);
    chk(rd_valid == 1'b0, "R4 glitch ignored", rd_valid, 0);
    frame(8, 9'h07E, 0, 0, 1, 64);
    drain("R4 after glitch");
    // R3: double speed, 8 ticks per bit
    dbl_speed = 1'b1; baud_div = 8'd7;
    frame(8, 9'h03C, 0, 0, 1, 64);
    frame(8, 9'h0B1, 0, 0, 1, 64);
    drain("R3 double speed");
    dbl_speed = 1'b0; baud_div = 8'd3;
    // R11: +-3% bit period at 5 bits
    char_sel = 3'd0;
    frame(5, 9'h015, 0, 0, 1, 66);
    frame(5, 9'h00A, 0, 0, 1, 62);
    drain("R11 tolerance");
    // R9 R10: overrun with two entries
    char_sel = 3'd3;
    frame(8, 9'h001, 0, 0, 1, 64);
    frame(8, 9'h002, 0, 0, 1, 64);
    frame(8, 9'h003, 0, 0, 1, 64);
    chk(ovr_seen == exp_ovr, "R10 overrun pulses", ovr_seen, exp_ovr);
    chk(exp_ovr == 1, "R10 overrun expected once", exp_ovr, 1);
    drain("R9 R10 order kept");

    $display("%0d/%0d checks passed", tot - bad, tot);
    $finish;
  end
endmodule